// File: doc/BRIEF.md
# Per-Channel Gamma Correction Table

This block is the colour-correction stage at the output of a display compositor that drives several output channels. Every channel owns three 256-entry, 8-bit tables: one each for red, green and blue. All of the tables are addressed as a single linear memory. Software fills that memory through a two-register port. The first register holds a word address and an auto-increment flag. The second register takes the data: each write to it stores one table entry.

On the pixel side, each incoming RGB pixel carries the number of the channel it belongs to. When that channel's gamma enable is set, each 8-bit component is replaced by the entry that it indexes in the matching colour table. When the enable is clear, the pixel passes through unchanged, which gives the same result as a linear table. The result appears one clock after the pixel. The valid, horizontal-sync and vertical-sync qualifiers are delayed by the same clock.

Top module: `chan_gamma_lut`

## Requirements
- R1: While `rst_n` is low, and after its release until the first pixel is accepted, `out_valid`, `out_hsync` and `out_vsync` are low.
- R2: A write with `reg_sel`=0 loads the address register. The address is taken from `reg_wdata[11:0]` and the auto-increment flag from `reg_wdata[15]`.
- R3: A write with `reg_sel`=1 stores `reg_wdata[7:0]` at the current address. When the flag is clear, the address does not change, so repeated writes replace the same entry.
- R4: When the flag is set, every data write advances the address by one. A data write at address 2303 (or above) moves the address to 0.
- R5: Entry (channel c, colour k, index i) lives at address c*768 + k*256 + i, where colour 0 is red, 1 is green and 2 is blue.
- R6: For a pixel on channel c with `gamma_en[c]`=1, `out_rgb[23:16]`, `[15:8]` and `[7:0]` are the red, green and blue table entries indexed by `pix_rgb[23:16]`, `[15:8]` and `[7:0]`.
- R7: When `gamma_en[c]`=0, or when `pix_chan` is 3 or higher, `out_rgb` equals `pix_rgb`. The enable is applied per pixel, so pixels of different channels may be interleaved back to back.
- R8: `out_valid`, `out_hsync`, `out_vsync` and `out_rgb` follow the pixel inputs with exactly one clock of latency.
- R9: A pixel that reads an entry in the same cycle as a data write to that entry sees the old value. A pixel in the next cycle sees the new value.
- R10: A data write while the address is 2304 or higher changes no table entry. The auto-increment rule of R4 still applies to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the address register, 1 selects the data register |
| reg_wdata | input | 16 | Register write value |
| gamma_en | input | 3 | Per-channel table enable |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_hsync | input | 1 | Input horizontal sync |
| pix_vsync | input | 1 | Input vertical sync |
| pix_chan | input | 2 | Channel the pixel belongs to |
| pix_rgb | input | 24 | Input pixel, red in the top byte |
| out_valid | output | 1 | Output pixel qualifier |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_rgb | output | 24 | Corrected pixel |

## Verification
The embedded assertions check the following on every cycle:
- the address register's load, hold, step and wrap behaviour;
- the one-clock alignment of valid and sync;
- the pass-through of pixels on disabled channels.

The table contents themselves can only be shown by the bench's scenarios:
- the memory is filled in full through the auto-incrementing port and then swept with every component value on every channel;
- the same-cycle write/read collision, the wrap at the top of the memory and the dropped out-of-range writes are each probed through pixel lookups.

// File: rtl/chan_gamma_pkg.sv
package chan_gamma_pkg;

  localparam int unsigned CG_COLOURS = 3;

  typedef enum logic [1:0] {
    COL_RED = 2'd0,
    COL_GRN = 2'd1,
    COL_BLU = 2'd2
  } cg_colour_e;

  typedef struct packed {
    logic valid;
    logic hsync;
    logic vsync;
  } cg_side_t;

endpackage

// File: rtl/cg_wr_port.sv
module cg_wr_port
  import chan_gamma_pkg::*;
#(
  parameter int unsigned NUM_CHAN    = 3,
  parameter int unsigned COMP_W      = 8,
  parameter int unsigned REG_W       = 16,
  parameter int unsigned AUTOINC_BIT = 15,
  parameter int unsigned AW          = 12,
  parameter int unsigned CSEL_W      = 2,
  parameter int unsigned BANK_AW     = CSEL_W + COMP_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic                          reg_sel,
  input  logic [REG_W-1:0]              reg_wdata,
  output logic [CG_COLOURS-1:0]         bank_we,
  output logic [BANK_AW-1:0]            bank_waddr,
  output logic [COMP_W-1:0]             bank_wdata
);

  localparam int unsigned ENTRIES = 1 << COMP_W;
  localparam int unsigned REGION  = CG_COLOURS * ENTRIES;
  localparam int unsigned DEPTH   = NUM_CHAN * REGION;

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [AW-1:0] DEPTH_A   = AW'(DEPTH);
  localparam logic [AW-1:0] REGION_A  = AW'(REGION);
  localparam logic [AW-1:0] ENTRIES_A = AW'(ENTRIES);

  logic [AW-1:0] addr_q, addr_d;
  logic          inc_q, inc_d;
  logic          addr_load, data_load;

  logic [AW-1:0] chan_part, rem_part, colour_part;
  logic          in_range;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[AUTOINC_BIT-1:AW];

  assign addr_load = reg_wr & ~reg_sel;
  assign data_load = reg_wr &  reg_sel;

  // next-state for the address register
  always_comb begin
    addr_d = addr_q;
    inc_d  = inc_q;
    if (addr_load) begin
      addr_d = reg_wdata[AW-1:0];
      inc_d  = reg_wdata[AUTOINC_BIT];
    end else if (data_load && inc_q) begin
      if (addr_q >= LAST_ADDR) addr_d = '0;
      else                     addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      inc_q  <= 1'b0;
    end else if (reg_wr) begin
      addr_q <= addr_d;
      inc_q  <= inc_d;
    end
  end

  // split the linear address into channel / colour / index
  always_comb begin
    in_range    = (addr_q < DEPTH_A);
    chan_part   = addr_q / REGION_A;
    rem_part    = addr_q % REGION_A;
    colour_part = rem_part / ENTRIES_A;
  end

  assign bank_waddr = {chan_part[CSEL_W-1:0], rem_part[COMP_W-1:0]};
  assign bank_wdata = reg_wdata[COMP_W-1:0];

  for (genvar k = 0; k < CG_COLOURS; k++) begin : g_we
    assign bank_we[k] = data_load & in_range & (colour_part == AW'(k));
  end

  a_r2_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> (addr_q == $past(reg_wdata[AW-1:0])) &&
                  (inc_q == $past(reg_wdata[AUTOINC_BIT])));

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (data_load && !inc_q) |=> $stable(addr_q) && $stable(inc_q));

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_load && inc_q && (addr_q < LAST_ADDR)) |=> (addr_q == $past(addr_q) + 1'b1));

  a_r4_addr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (data_load && inc_q && (addr_q >= LAST_ADDR)) |=> (addr_q == '0));

endmodule

// File: rtl/cg_bank.sv
module cg_bank #(
  parameter int unsigned COMP_W = 8,
  parameter int unsigned DEPTH  = 768,
  parameter int unsigned AW     = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [COMP_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [COMP_W-1:0] rdata
);

  logic [COMP_W-1:0] mem [DEPTH];

  // write and read share the edge; the read returns the value before the write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cg_pix_pipe.sv
module cg_pix_pipe
  import chan_gamma_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 3,
  parameter int unsigned COMP_W   = 8,
  parameter int unsigned CHAN_W   = 2,
  parameter int unsigned CSEL_W   = 2,
  parameter int unsigned BANK_AW  = CSEL_W + COMP_W
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_CHAN-1:0]                   gamma_en,
  input  logic                                  pix_valid,
  input  logic                                  pix_hsync,
  input  logic                                  pix_vsync,
  input  logic [CHAN_W-1:0]                     pix_chan,
  input  logic [CG_COLOURS*COMP_W-1:0]          pix_rgb,
  output logic [CG_COLOURS-1:0][BANK_AW-1:0]    lut_raddr,
  input  logic [CG_COLOURS-1:0][COMP_W-1:0]     lut_rdata,
  output logic                                  out_valid,
  output logic                                  out_hsync,
  output logic                                  out_vsync,
  output logic [CG_COLOURS*COMP_W-1:0]          out_rgb
);

  localparam int unsigned PIX_W = CG_COLOURS * COMP_W;
  localparam logic [CHAN_W-1:0] CHAN_LIM = CHAN_W'(NUM_CHAN);

  logic     chan_ok, en_sel, use_lut;
  cg_side_t side_d, side_q;
  logic     use_q;
  logic [PIX_W-1:0] byp_q;
  logic [PIX_W-1:0] lut_word;

  always_comb begin
    chan_ok = (pix_chan < CHAN_LIM);
    en_sel  = 1'b0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (pix_chan == CHAN_W'(c)) en_sel = gamma_en[c];
    end
    use_lut = chan_ok & en_sel;
  end

  // colour 0 (red) sits in the top byte of the pixel
  for (genvar k = 0; k < CG_COLOURS; k++) begin : g_rd
    localparam int unsigned LSB = (CG_COLOURS - 1 - k) * COMP_W;
    assign lut_raddr[k] = chan_ok ? {pix_chan[CSEL_W-1:0], pix_rgb[LSB +: COMP_W]}
                                  : '0;
    assign lut_word[LSB +: COMP_W] = lut_rdata[k];
  end

  always_comb begin
    side_d.valid = pix_valid;
    side_d.hsync = pix_hsync;
    side_d.vsync = pix_vsync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) side_q <= '0;
    else        side_q <= side_d;
  end

  always_ff @(posedge clk) begin
    if (pix_valid) begin
      use_q <= use_lut;
      byp_q <= pix_rgb;
    end
  end

  assign out_valid = side_q.valid;
  assign out_hsync = side_q.hsync;
  assign out_vsync = side_q.vsync;
  assign out_rgb   = use_q ? lut_word : byp_q;

  a_r8_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  a_r8_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);

  a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_hsync == $past(pix_hsync)) && (out_vsync == $past(pix_vsync)));

  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !use_lut) |=> (out_rgb == $past(pix_rgb)));

endmodule

// File: rtl/chan_gamma_lut.sv
module chan_gamma_lut
  import chan_gamma_pkg::*;
#(
  parameter int unsigned NUM_CHAN    = 3,
  parameter int unsigned COMP_W      = 8,
  parameter int unsigned REG_W       = 16,
  parameter int unsigned AUTOINC_BIT = 15,
  parameter int unsigned CHAN_W      = $clog2(NUM_CHAN + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic                         reg_sel,
  input  logic [REG_W-1:0]             reg_wdata,
  input  logic [NUM_CHAN-1:0]          gamma_en,
  input  logic                         pix_valid,
  input  logic                         pix_hsync,
  input  logic                         pix_vsync,
  input  logic [CHAN_W-1:0]            pix_chan,
  input  logic [CG_COLOURS*COMP_W-1:0] pix_rgb,
  output logic                         out_valid,
  output logic                         out_hsync,
  output logic                         out_vsync,
  output logic [CG_COLOURS*COMP_W-1:0] out_rgb
);

  localparam int unsigned ENTRIES    = 1 << COMP_W;
  localparam int unsigned DEPTH      = NUM_CHAN * CG_COLOURS * ENTRIES;
  localparam int unsigned AW         = $clog2(DEPTH);
  localparam int unsigned CSEL_W     = $clog2(NUM_CHAN);
  localparam int unsigned BANK_AW    = CSEL_W + COMP_W;
  localparam int unsigned BANK_DEPTH = NUM_CHAN * ENTRIES;

  logic [CG_COLOURS-1:0]              bank_we;
  logic [BANK_AW-1:0]                 bank_waddr;
  logic [COMP_W-1:0]                  bank_wdata;
  logic [CG_COLOURS-1:0][BANK_AW-1:0] lut_raddr;
  logic [CG_COLOURS-1:0][COMP_W-1:0]  lut_rdata;

  cg_wr_port #(
    .NUM_CHAN    (NUM_CHAN),
    .COMP_W      (COMP_W),
    .REG_W       (REG_W),
    .AUTOINC_BIT (AUTOINC_BIT),
    .AW          (AW),
    .CSEL_W      (CSEL_W),
    .BANK_AW     (BANK_AW)
  ) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .bank_we    (bank_we),
    .bank_waddr (bank_waddr),
    .bank_wdata (bank_wdata)
  );

  for (genvar k = 0; k < CG_COLOURS; k++) begin : g_bank
    cg_bank #(
      .COMP_W (COMP_W),
      .DEPTH  (BANK_DEPTH),
      .AW     (BANK_AW)
    ) u_bank (
      .clk   (clk),
      .we    (bank_we[k]),
      .waddr (bank_waddr),
      .wdata (bank_wdata),
      .raddr (lut_raddr[k]),
      .rdata (lut_rdata[k])
    );
  end

  cg_pix_pipe #(
    .NUM_CHAN (NUM_CHAN),
    .COMP_W   (COMP_W),
    .CHAN_W   (CHAN_W),
    .CSEL_W   (CSEL_W),
    .BANK_AW  (BANK_AW)
  ) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .gamma_en  (gamma_en),
    .pix_valid (pix_valid),
    .pix_hsync (pix_hsync),
    .pix_vsync (pix_vsync),
    .pix_chan  (pix_chan),
    .pix_rgb   (pix_rgb),
    .lut_raddr (lut_raddr),
    .lut_rdata (lut_rdata),
    .out_valid (out_valid),
    .out_hsync (out_hsync),
    .out_vsync (out_vsync),
    .out_rgb   (out_rgb)
  );

endmodule

// File: tb/chan_gamma_lut_tb.sv
module chan_gamma_lut_tb;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_sel;
  logic [15:0] reg_wdata;
  logic [2:0]  gamma_en;
  logic        pix_valid, pix_hsync, pix_vsync;
  logic [1:0]  pix_chan;
  logic [23:0] pix_rgb;
  logic        out_valid, out_hsync, out_vsync;
  logic [23:0] out_rgb;

  int n_cmp;
  int n_bad;
  bit done;
  logic [7:0] model [2304];

  chan_gamma_lut u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .gamma_en  (gamma_en),
    .pix_valid (pix_valid),
    .pix_hsync (pix_hsync),
    .pix_vsync (pix_vsync),
    .pix_chan  (pix_chan),
    .pix_rgb   (pix_rgb),
    .out_valid (out_valid),
    .out_hsync (out_hsync),
    .out_vsync (out_vsync),
    .out_rgb   (out_rgb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] fill_val(input int a);
    return 8'((a * 7 + (a >> 8) * 13 + 3) & 255);
  endfunction

  function automatic logic [23:0] expect_px(input int ch, input logic [23:0] rgb,
                                            input logic [2:0] en);
    if (ch < 3 && en[ch])
      return {model[ch*768 + int'(rgb[23:16])],
              model[ch*768 + 256 + int'(rgb[15:8])],
              model[ch*768 + 512 + int'(rgb[7:0])]};
    return rgb;
  endfunction

  task automatic check(input bit ok, input string req, input logic [26:0] act,
                       input logic [26:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // caller sits just after a falling edge; returns just after the next one
  task automatic reg_write(input logic sel, input logic [15:0] val);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic data_write(input int a, input logic [7:0] v);
    reg_write(1'b1, {8'h00, v});
    if (a < 2304) model[a] = v;
  endtask

  task automatic pix_step(input logic v, input int ch, input logic [23:0] rgb,
                          input logic hs, input logic vs, input string req);
    logic [23:0] exp;
    exp = expect_px(ch, rgb, gamma_en);
    pix_valid = v; pix_chan = 2'(ch); pix_rgb = rgb; pix_hsync = hs; pix_vsync = vs;
    @(negedge clk);
    check((out_valid == v) && (out_hsync == hs) && (out_vsync == vs) &&
          (!v || out_rgb == exp), req,
          {out_valid, out_hsync, out_vsync, out_rgb}, {v, hs, vs, exp});
  endtask

  task automatic sweep(input int ch, input string req);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b;
      b = 8'(i);
      pix_step(1'b1, ch, {b, b ^ 8'hA5, ~b}, b[0], (i == 0), req);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    gamma_en = 3'b000; pix_valid = 1'b0; pix_hsync = 1'b0; pix_vsync = 1'b0;
    pix_chan = '0; pix_rgb = '0;
    for (int a = 0; a < 2304; a++) model[a] = 8'h00;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!out_valid && !out_hsync && !out_vsync, "R1",
          {out_valid, out_hsync, out_vsync, 24'h0}, 27'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !out_hsync && !out_vsync, "R1",
          {out_valid, out_hsync, out_vsync, 24'h0}, 27'h0);

    // R2 R4 R5: fill the whole memory through the auto-incrementing port
    reg_write(1'b0, 16'h8000);
    for (int a = 0; a < 2304; a++) data_write(a, fill_val(a));

    // R6 R5 R8: every component value on every enabled channel
    gamma_en = 3'b111;
    for (int ch = 0; ch < 3; ch++) sweep(ch, "R6");
    pix_step(1'b0, 0, 24'h0, 1'b0, 1'b0, "R8");

    // R7: disabled channels pass through
    gamma_en = 3'b000;
    for (int ch = 0; ch < 3; ch++) sweep(ch, "R7");
    gamma_en = 3'b111;
    sweep(3, "R7");
    // R7: interleaved lookup and bypass channels
    gamma_en = 3'b101;
    for (int i = 0; i < 64; i++) begin
      logic [7:0] b;
      b = 8'(i * 5);
      pix_step(1'b1, i % 3, {b, ~b, b + 8'd17}, b[1], b[2], "R7");
    end
    gamma_en = 3'b111;

    // R3: no auto-increment rewrites one entry (ch0 green index 44 = 300)
    reg_write(1'b0, 16'd300);
    data_write(300, 8'h11);
    data_write(300, 8'h22);
    pix_step(1'b1, 0, {8'd0, 8'd44, 8'd0}, 1'b0, 1'b0, "R3");
    pix_step(1'b1, 0, {8'd0, 8'd45, 8'd0}, 1'b0, 1'b0, "R3");

    // R4: wrap from the last address back to zero, then keep going
    reg_write(1'b0, 16'h8000 | 16'd2303);
    data_write(2303, 8'hC3);
    data_write(0, 8'h3C);
    data_write(1, 8'h77);
    pix_step(1'b1, 2, {8'd0, 8'd0, 8'd255}, 1'b0, 1'b0, "R4");
    pix_step(1'b1, 0, {8'd0, 8'd0, 8'd0}, 1'b0, 1'b0, "R4");
    pix_step(1'b1, 0, {8'd1, 8'd0, 8'd0}, 1'b0, 1'b0, "R4");

    // R10: out-of-range write dropped, address then wraps to 0
    reg_write(1'b0, 16'h8000 | 16'd2400);
    data_write(2400, 8'h99);
    data_write(0, 8'h98);
    pix_step(1'b1, 0, {8'd0, 8'd0, 8'd0}, 1'b0, 1'b0, "R10");
    for (int ch = 0; ch < 3; ch++) sweep(ch, "R10");

    // R9: write and read of address 10 in the same cycle
    reg_write(1'b0, 16'd10);
    begin
      logic [7:0] old_v;
      old_v = model[10];
      reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h00E1;
      pix_valid = 1'b1; pix_chan = 2'd0; pix_rgb = {8'd10, 8'd0, 8'd0};
      pix_hsync = 1'b0; pix_vsync = 1'b0;
      @(negedge clk);
      reg_wr = 1'b0;
      model[10] = 8'hE1;
      check(out_valid && out_rgb[23:16] == old_v, "R9",
            {out_valid, 2'b00, out_rgb}, {1'b1, 2'b00, old_v, 16'h0});
      pix_step(1'b1, 0, {8'd10, 8'd0, 8'd0}, 1'b0, 1'b0, "R9");
    end
    pix_step(1'b0, 0, 24'h0, 1'b0, 1'b0, "R8");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule